// File: doc/BRIEF.md
# Byte-Wide Configuration Load Sequencer

This block loads a configuration stream into a programmable device that accepts one byte per eight configuration clocks on a synchronous byte-wide port. A host starts a load by giving the number of bytes to send. The sequencer first pulls the device's program-request pin and its open-drain ready/error line low together for a fixed number of system clocks. It then releases both and waits, with a time limit, for the ready line to read high. A single long clock pulse follows. From then on the sequencer takes one byte at a time from the host, puts it on the data pins and issues eight configuration clocks.

After each burst the sequencer samples the ready/error line once, without waiting. A low level aborts the load. When the last byte has gone out, the sequencer reads the device's completion pin and reports success or failure. The ready/error and completion inputs pass through a two-flop synchroniser. The open-drain line is modelled as a drive-low enable, so the line reads low whenever the sequencer or the device pulls it.

Top module: `cfg_loader`

## Requirements
- R1: While reset is held and right after it: busy, ok, err, wrReady, cclk and initDrvLow are 0, progN is 1, and bytesSent and dOut are 0.
- R2: A start sampled in idle latches totalBytes, clears ok, err and bytesSent, and holds progN low for exactly RESET_CYCLES clocks. A start sampled while busy is ignored.
- R3: initDrvLow is 1 exactly while progN is 0. After the reset phase both are released, and no cclk pulse occurs until initIn, after two synchroniser flops, reads 1.
- R4: If initIn is not seen high within INIT_TIMEOUT clocks of waiting, the load ends with err=1, ok=0 and bytesSent=0, and no cclk pulse is given.
- R5: Before the first byte, cclk gives one pulse that is LONE_HIGH clocks high, followed by CCLK_LOW clocks low.
- R6: wrReady is 1 only between bursts. A byte is taken on a rising clock edge where wrValid and wrReady are both 1. A wrValid at any other time is ignored and consumes no byte.
- R7: A taken byte appears on dOut from the accepting edge and stays there until the next byte is taken. It is followed by eight cclk pulses, each CCLK_HIGH clocks high and CCLK_LOW clocks low.
- R8: In the single clock after each burst, the synchronised initIn is sampled. If it is 0, the load ends with err=1, and the aborted byte is counted in bytesSent.
- R9: bytesSent rises by exactly one per finished burst and is never otherwise changed except cleared at start.
- R10: When bytesSent reaches the latched totalBytes, or right after the single pulse when totalBytes is 0, the synchronised doneIn is read once: 1 gives ok=1, and 0 gives err=1.
- R11: ok and err are never both 1. When busy falls, exactly one of them is 1, and both hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (one-clock pulse, taken in idle only) |
| totalBytes | input | CNT_W | Number of bytes in the load, latched at start |
| wrValid | input | 1 | Host has a byte on wrData |
| wrData | input | DATA_W | Host byte |
| wrReady | output | 1 | Sequencer can take a byte this clock |
| progN | output | 1 | Program request to the device, low active |
| initDrvLow | output | 1 | Drive-low enable for the open-drain ready/error line |
| initIn | input | 1 | Level read back from the ready/error line |
| cclk | output | 1 | Configuration clock |
| dOut | output | DATA_W | Configuration data pins |
| doneIn | input | 1 | Completion pin of the device |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load ended with completion high |
| err | output | 1 | Last load ended by timeout, byte error or completion low |
| bytesSent | output | CNT_W | Bursts finished in the current or last load |

## Verification
The bench builds the block with RESET_CYCLES=10, INIT_TIMEOUT=50, LONE_HIGH=4, CCLK_HIGH=2, CCLK_LOW=3 and CNT_W=8. With these values the time-out expiry, the abort on the last-sampled byte and several complete loads each fit in a few hundred clocks. The unequal high and low times show any swap of the two clock phases. The bench's model also applies the two-clock synchroniser delay to the ready line, so the exact clock in which an abort takes effect is checked. Host traffic includes bytes offered before a load starts, bytes offered on alternate clocks, a zero-length load and a second start pulse during a burst.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET,
    ST_WAITINIT,
    ST_LONEHI,
    ST_LONELO,
    ST_WAITBYTE,
    ST_BITHI,
    ST_BITLO,
    ST_POLL,
    ST_DONECHK
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrClr;
    logic tmrInc;
    logic bitClr;
    logic bitInc;
    logic loadByte;
    logic startLoad;
    logic cntInc;
    logic setOk;
    logic setErr;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic hitReset;
    logic hitTimeout;
    logic hitLone;
    logic hitHigh;
    logic hitLow;
    logic lastBit;
    logic lastByte;
    logic noBytes;
    logic initHigh;
    logic doneHigh;
  } dpStatus_t;

  function automatic int cfglMax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfgl_dpath.sv
module cfgl_dpath
  import cfgl_pkg::*;
#(
  parameter int RESET_CYCLES = 10000,
  parameter int INIT_TIMEOUT = 200000,
  parameter int LONE_HIGH    = 64,
  parameter int CCLK_HIGH    = 4,
  parameter int CCLK_LOW     = 4,
  parameter int CNT_W        = 20,
  parameter int DATA_W       = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [CNT_W-1:0]  totalBytes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              initIn,
  input  logic              doneIn,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] dOut,
  output logic [CNT_W-1:0]  bytesSent,
  output logic              ok,
  output logic              err
);
  localparam int TMR_MAX = cfglMax(cfglMax(RESET_CYCLES, INIT_TIMEOUT),
                                   cfglMax(LONE_HIGH, cfglMax(CCLK_HIGH, CCLK_LOW)));
  localparam int TMR_W   = (TMR_MAX < 2) ? 1 : $clog2(TMR_MAX);
  localparam int BIT_W   = (DATA_W < 2) ? 1 : $clog2(DATA_W);
  localparam int N_SYNC  = 2;

  logic [TMR_W-1:0]  tmr;
  logic [BIT_W-1:0]  bitIdx;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  total;
  logic [DATA_W-1:0] dReg;
  logic              okR;
  logic              errR;

  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] syncIn;

  assign rawIn = {doneIn, initIn};

  genvar gi;
  generate
    for (gi = 0; gi < N_SYNC; gi++) begin : g_sync
      cfgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rstN (rstN),
        .d    (rawIn[gi]),
        .q    (syncIn[gi])
      );
    end
  endgenerate

  // phase timer shared by all timed states
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tmr <= '0;
    else if (strobe.tmrClr) tmr <= '0;
    else if (strobe.tmrInc) tmr <= tmr + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitIdx <= '0;
    else if (strobe.bitClr) bitIdx <= '0;
    else if (strobe.bitInc) bitIdx <= bitIdx + BIT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      total <= '0;
    end else if (strobe.startLoad) begin
      cnt   <= '0;
      total <= totalBytes;
    end else if (strobe.cntInc) begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dReg <= '0;
    else if (strobe.loadByte) dReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okR  <= 1'b0;
      errR <= 1'b0;
    end else if (strobe.startLoad) begin
      okR  <= 1'b0;
      errR <= 1'b0;
    end else begin
      if (strobe.setOk)  okR  <= 1'b1;
      if (strobe.setErr) errR <= 1'b1;
    end
  end

  always_comb begin
    status.hitReset   = (tmr == TMR_W'(RESET_CYCLES - 1));
    status.hitTimeout = (tmr == TMR_W'(INIT_TIMEOUT - 1));
    status.hitLone    = (tmr == TMR_W'(LONE_HIGH - 1));
    status.hitHigh    = (tmr == TMR_W'(CCLK_HIGH - 1));
    status.hitLow     = (tmr == TMR_W'(CCLK_LOW - 1));
    status.lastBit    = (bitIdx == BIT_W'(DATA_W - 1));
    status.lastByte   = ((cnt + CNT_W'(1)) == total);
    status.noBytes    = (total == '0);
    status.initHigh   = syncIn[0];
    status.doneHigh   = syncIn[1];
  end

  assign dOut      = dReg;
  assign bytesSent = cnt;
  assign ok        = okR;
  assign err       = errR;
endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        wrValid,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        progN,
  output logic        initDrvLow,
  output logic        cclk,
  output logic        wrReady,
  output logic        busy
);
  seqState_t st;
  seqState_t stNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNx;
  end

  always_comb begin
    stNx   = st;
    strobe = '0;
    case (st)
      ST_IDLE: begin
        if (start) begin
          strobe.startLoad = 1'b1;
          strobe.tmrClr    = 1'b1;
          stNx             = ST_RESET;
        end
      end
      ST_RESET: begin
        if (status.hitReset) begin
          strobe.tmrClr = 1'b1;
          stNx          = ST_WAITINIT;
        end else begin
          strobe.tmrInc = 1'b1;
        end
      end
      ST_WAITINIT: begin
        if (status.initHigh) begin
          strobe.tmrClr = 1'b1;
          stNx          = ST_LONEHI;
        end else if (status.hitTimeout) begin
          strobe.setErr = 1'b1;
          stNx          = ST_IDLE;
        end else begin
          strobe.tmrInc = 1'b1;
        end
      end
      ST_LONEHI: begin
        if (status.hitLone) begin
          strobe.tmrClr = 1'b1;
          stNx          = ST_LONELO;
        end else begin
          strobe.tmrInc = 1'b1;
        end
      end
      ST_LONELO: begin
        if (status.hitLow) begin
          strobe.tmrClr = 1'b1;
          stNx          = status.noBytes ? ST_DONECHK : ST_WAITBYTE;
        end else begin
          strobe.tmrInc = 1'b1;
        end
      end
      ST_WAITBYTE: begin
        if (wrValid) begin
          strobe.loadByte = 1'b1;
          strobe.bitClr   = 1'b1;
          strobe.tmrClr   = 1'b1;
          stNx            = ST_BITHI;
        end
      end
      ST_BITHI: begin
        if (status.hitHigh) begin
          strobe.tmrClr = 1'b1;
          stNx          = ST_BITLO;
        end else begin
          strobe.tmrInc = 1'b1;
        end
      end
      ST_BITLO: begin
        if (status.hitLow) begin
          strobe.tmrClr = 1'b1;
          if (status.lastBit) begin
            stNx = ST_POLL;
          end else begin
            strobe.bitInc = 1'b1;
            stNx          = ST_BITHI;
          end
        end else begin
          strobe.tmrInc = 1'b1;
        end
      end
      ST_POLL: begin
        strobe.cntInc = 1'b1;
        if (!status.initHigh) begin
          strobe.setErr = 1'b1;
          stNx          = ST_IDLE;
        end else if (status.lastByte) begin
          stNx = ST_DONECHK;
        end else begin
          stNx = ST_WAITBYTE;
        end
      end
      ST_DONECHK: begin
        if (status.doneHigh) strobe.setOk  = 1'b1;
        else                 strobe.setErr = 1'b1;
        stNx = ST_IDLE;
      end
      default: stNx = ST_IDLE;
    endcase
  end

  assign progN      = (st != ST_RESET);
  assign initDrvLow = (st == ST_RESET);
  assign cclk       = (st == ST_LONEHI) || (st == ST_BITHI);
  assign wrReady    = (st == ST_WAITBYTE);
  assign busy       = (st != ST_IDLE);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgl_pkg::*;
#(
  parameter int RESET_CYCLES = 10000,
  parameter int INIT_TIMEOUT = 200000,
  parameter int LONE_HIGH    = 64,
  parameter int CCLK_HIGH    = 4,
  parameter int CCLK_LOW     = 4,
  parameter int CNT_W        = 20,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  totalBytes,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  output logic              progN,
  output logic              initDrvLow,
  input  logic              initIn,
  output logic              cclk,
  output logic [DATA_W-1:0] dOut,
  input  logic              doneIn,
  output logic              busy,
  output logic              ok,
  output logic              err,
  output logic [CNT_W-1:0]  bytesSent
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  cfgl_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .wrValid    (wrValid),
    .status     (status),
    .strobe     (strobe),
    .progN      (progN),
    .initDrvLow (initDrvLow),
    .cclk       (cclk),
    .wrReady    (wrReady),
    .busy       (busy)
  );

  cfgl_dpath #(
    .RESET_CYCLES (RESET_CYCLES),
    .INIT_TIMEOUT (INIT_TIMEOUT),
    .LONE_HIGH    (LONE_HIGH),
    .CCLK_HIGH    (CCLK_HIGH),
    .CCLK_LOW     (CCLK_LOW),
    .CNT_W        (CNT_W),
    .DATA_W       (DATA_W),
    .SYNC_STAGES  (2)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .totalBytes (totalBytes),
    .wrData     (wrData),
    .initIn     (initIn),
    .doneIn     (doneIn),
    .status     (status),
    .dOut       (dOut),
    .bytesSent  (bytesSent),
    .ok         (ok),
    .err        (err)
  );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              progN,
  input logic              initDrvLow,
  input logic              cclk,
  input logic              wrReady,
  input logic [DATA_W-1:0] dOut,
  input logic              busy,
  input logic              ok,
  input logic              err,
  input logic [CNT_W-1:0]  bytesSent
);
  // R3
  pins_paired_chk: assert property (@(posedge clk) disable iff (!rstN)
    progN != initDrvLow);

  // R3
  no_clk_in_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> !cclk);

  // R6
  ready_between_bursts_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (!cclk && busy));

  // R7
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrReady |=> $stable(dOut));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bytesSent) |-> ((bytesSent == CNT_W'($past(bytesSent) + CNT_W'(1))) || (bytesSent == '0)));

  // R11
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ok && err));

  // R11
  finish_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (ok || err));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cclk && progN && !wrReady));
endmodule

bind cfg_loader cfg_loader_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .progN      (progN),
  .initDrvLow (initDrvLow),
  .cclk       (cclk),
  .wrReady    (wrReady),
  .dOut       (dOut),
  .busy       (busy),
  .ok         (ok),
  .err        (err),
  .bytesSent  (bytesSent)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;
  localparam int RST_C = 10;
  localparam int TO_C  = 50;
  localparam int LH_C  = 4;
  localparam int HI_C  = 2;
  localparam int LO_C  = 3;
  localparam int CW    = 8;

  localparam int M_IDLE = 0, M_RST = 1, M_WAIT = 2, M_LH = 3, M_LL = 4,
                 M_WB = 5, M_BH = 6, M_BL = 7, M_POLL = 8, M_DONE = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] totalBytes = '0;
  logic wrValid = 1'b0;
  logic [7:0] wrData = '0;
  logic wrReady, progN, initDrvLow, initIn, cclk, busy, ok, err;
  logic [7:0] dOut;
  logic doneIn;
  logic [CW-1:0] bytesSent;

  logic tgtLow  = 1'b1;
  logic tgtDone = 1'b0;

  assign initIn = !initDrvLow && !tgtLow;
  assign doneIn = tgtDone;

  always #2.5 clk = ~clk;

  cfg_loader #(
    .RESET_CYCLES (RST_C),
    .INIT_TIMEOUT (TO_C),
    .LONE_HIGH    (LH_C),
    .CCLK_HIGH    (HI_C),
    .CCLK_LOW     (LO_C),
    .CNT_W        (CW),
    .DATA_W       (8)
  ) u_cfg_loader (
    .clk(clk), .rstN(rstN), .start(start), .totalBytes(totalBytes),
    .wrValid(wrValid), .wrData(wrData), .wrReady(wrReady),
    .progN(progN), .initDrvLow(initDrvLow), .initIn(initIn),
    .cclk(cclk), .dOut(dOut), .doneIn(doneIn), .busy(busy),
    .ok(ok), .err(err), .bytesSent(bytesSent)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mPh = M_IDLE, mT = 0, mBit = 0, mCnt = 0, mTot = 0;
  int mOk = 0, mErr = 0, mByte = 0;
  int s1 = 0, s2 = 0, d1 = 0, d2 = 0;
  bit modelLive = 0;

  always @(posedge clk) begin
    modelLive = 1;
    if (!rstN) begin
      mPh = M_IDLE; mT = 0; mBit = 0; mCnt = 0; mTot = 0;
      mOk = 0; mErr = 0; mByte = 0; s1 = 0; s2 = 0; d1 = 0; d2 = 0;
    end else begin
      case (mPh)
        M_IDLE: if (start) begin
          mTot = int'(totalBytes); mCnt = 0; mOk = 0; mErr = 0; mT = 0; mPh = M_RST;
        end
        M_RST: if (mT == RST_C - 1) begin mT = 0; mPh = M_WAIT; end else mT++;
        M_WAIT: begin
          if (s2 == 1) begin mT = 0; mPh = M_LH; end
          else if (mT == TO_C - 1) begin mErr = 1; mPh = M_IDLE; end
          else mT++;
        end
        M_LH: if (mT == LH_C - 1) begin mT = 0; mPh = M_LL; end else mT++;
        M_LL: if (mT == LO_C - 1) begin mT = 0; mPh = (mTot == 0) ? M_DONE : M_WB; end else mT++;
        M_WB: if (wrValid) begin mByte = int'(wrData); mBit = 0; mT = 0; mPh = M_BH; end
        M_BH: if (mT == HI_C - 1) begin mT = 0; mPh = M_BL; end else mT++;
        M_BL: if (mT == LO_C - 1) begin
          mT = 0;
          if (mBit == 7) mPh = M_POLL;
          else begin mBit++; mPh = M_BH; end
        end else mT++;
        M_POLL: begin
          mCnt++;
          if (s2 == 0) begin mErr = 1; mPh = M_IDLE; end
          else if (mCnt == mTot) mPh = M_DONE;
          else mPh = M_WB;
        end
        M_DONE: begin
          if (d2 == 1) mOk = 1; else mErr = 1;
          mPh = M_IDLE;
        end
        default: mPh = M_IDLE;
      endcase
      s2 = s1; s1 = int'(initIn);
      d2 = d1; d1 = int'(doneIn);
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (modelLive) begin
      chk("R2",  "progN",      int'(progN),      (mPh != M_RST) ? 1 : 0);
      chk("R3",  "initDrvLow", int'(initDrvLow), (mPh == M_RST) ? 1 : 0);
      chk("R5",  "cclk",       int'(cclk),       (mPh == M_LH || mPh == M_BH) ? 1 : 0);
      chk("R6",  "wrReady",    int'(wrReady),    (mPh == M_WB) ? 1 : 0);
      chk("R7",  "dOut",       int'(dOut),       mByte);
      chk("R9",  "bytesSent",  int'(bytesSent),  mCnt);
      chk("R10", "ok",         int'(ok),         mOk);
      chk("R11", "err",        int'(err),        mErr);
      chk("R4",  "busy",       int'(busy),       (mPh != M_IDLE) ? 1 : 0);
    end
  end

  // host byte source: offers bytes whenever it has some
  logic [7:0] hq[$];
  int  accCnt = 0;
  bit  accNext = 0;
  bit  gapMode = 0;
  bit  gapTog = 0;

  always @(negedge clk) begin
    if (accNext) begin
      void'(hq.pop_front());
      accCnt++;
    end
    accNext = 0;
    gapTog = ~gapTog;
    if (hq.size() > 0 && !(gapMode && gapTog)) begin
      wrValid = 1'b1;
      wrData  = hq[0];
    end else begin
      wrValid = 1'b0;
      wrData  = 8'h00;
    end
    if (wrValid && wrReady) accNext = 1;
  end

  int cclkRise = 0;
  always @(posedge cclk) cclkRise++;

  task automatic runLoad(input int n, input bit dn, input int errAt,
                         input bit neverReady, input bit gap, input bit restart,
                         input int seed);
    hq.delete();
    for (int i = 0; i < n; i++) hq.push_back(8'((i * 37 + seed) ^ 8'h5A));
    accCnt = 0;
    cclkRise = 0;
    tgtDone = dn;
    gapMode = gap;
    tgtLow = 1'b1;
    @(negedge clk);
    totalBytes = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!progN) @(negedge clk);
    repeat (5) @(negedge clk);
    if (!neverReady) tgtLow = 1'b0;
    if (restart) begin
      while (accCnt < 1 && busy) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    if (errAt >= 0) begin
      while (accCnt < errAt + 1 && busy) @(negedge clk);
      tgtLow = 1'b1;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy",       int'(busy), 0);
    chk("R1", "progN",      int'(progN), 1);
    chk("R1", "initDrvLow", int'(initDrvLow), 0);
    chk("R1", "cclk",       int'(cclk), 0);
    chk("R1", "okErr",      int'(ok) + int'(err), 0);
    chk("R1", "bytesSent",  int'(bytesSent), 0);
    chk("R1", "dOut",       int'(dOut), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "wrReady after release", int'(wrReady), 0);

    // full load, completion high
    runLoad(5, 1'b1, -1, 1'b0, 1'b0, 1'b0, 3);
    chk("R10", "ok after good load", int'(ok), 1);
    chk("R9",  "count good load", int'(bytesSent), 5);
    chk("R7",  "cclk pulses good load", cclkRise, 1 + 8 * 5);

    // completion low, host with gaps
    runLoad(3, 1'b0, -1, 1'b0, 1'b1, 1'b0, 11);
    chk("R10", "err on completion low", int'(err), 1);
    chk("R10", "ok on completion low", int'(ok), 0);
    chk("R7",  "cclk pulses gap load", cclkRise, 1 + 8 * 3);

    // error line drops during third byte
    runLoad(6, 1'b1, 2, 1'b0, 1'b0, 1'b0, 29);
    chk("R8", "err on byte error", int'(err), 1);
    chk("R8", "count includes aborted byte", int'(bytesSent), 3);
    chk("R8", "cclk pulses aborted", cclkRise, 1 + 8 * 3);
    chk("R6", "untaken bytes remain", hq.size(), 3);

    // device never ready
    runLoad(4, 1'b1, -1, 1'b1, 1'b0, 1'b0, 50);
    chk("R4", "err on timeout", int'(err), 1);
    chk("R4", "count on timeout", int'(bytesSent), 0);
    chk("R4", "no cclk on timeout", cclkRise, 0);
    chk("R6", "no byte taken on timeout", hq.size(), 4);

    // zero-length load
    runLoad(0, 1'b1, -1, 1'b0, 1'b0, 1'b0, 0);
    chk("R10", "ok zero-length", int'(ok), 1);
    chk("R5",  "single pulse zero-length", cclkRise, 1);

    // second start during a burst is ignored
    runLoad(4, 1'b1, -1, 1'b0, 1'b0, 1'b1, 77);
    chk("R2", "restart ignored ok", int'(ok), 1);
    chk("R2", "restart ignored count", int'(bytesSent), 4);
    chk("R11", "exclusive flags", int'(ok) + int'(err), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule